// File: doc/BRIEF.md
# Volt-Second Limit Duty Skew Corrector

This block guards the transformer of a full-bridge converter against core saturation. A signed running integral of the volt-second error arrives once per switching period, together with a valid strobe. The block compares it against two critical limits that scale with the amplitude code of the bridge voltage: the positive limit is `lim_mult_pos * amp` and the negative limit is `-(lim_mult_neg * amp)`. When either limit is reached, the block prepares pulse widths for the next period. The two half-waves are skewed by the same count in opposite directions, so the accumulated error is cancelled within that one period and the core never reaches saturation.

The correction count is the magnitude of the integral divided by twice the amplitude code. A shared restoring divider produces it one quotient bit per clock, which fits well within a switching period. Every evaluation produces a fresh pair of widths. A triggered evaluation carries the skewed pair and a one-cycle override strobe. An untriggered evaluation returns both widths to the nominal count. A skew therefore never outlives the period it was computed for. With an amplitude multiplier of 400 on both sides, the limits are plus and minus 400 amplitude units.

Top module: `vsec_skew_corrector`

## Requirements
- R1: When the captured integral is greater than or equal to `lim_mult_pos*amp`, the result sets `trig_pos`=1 and `trig_neg`=0, makes `np_out` the shortened width and `nn_out` the lengthened width, and pulses `ovr_vld`.
- R2: When the captured integral is less than or equal to `-(lim_mult_neg*amp)` and R1 does not apply, the result sets `trig_neg`=1, makes `np_out` the lengthened width and `nn_out` the shortened width, and pulses `ovr_vld`.
- R3: The skew count equals floor(|integral| / (2*amp)). The lengthened width is `n0`+skew and the shortened width is `n0`-skew, both before clamping.
- R4: When neither limit is reached, both widths equal `n0`, both trigger flags are 0 and `ovr_vld` stays 0.
- R5: Every output width is clamped to the range 0 to MAX_CNT. This applies to the lengthened, the shortened and the nominal width.
- R6: `ovr_vld` is high for exactly one cycle per triggered evaluation. The following untriggered evaluation restores the nominal widths.
- R7: The outputs take their new values on the (IW+1)th rising edge after the edge that samples `integ_vld` high, which is the 33rd edge with defaults. They hold their values in between.
- R8: An `integ_vld` strobe that arrives while an evaluation is in progress is ignored. Inputs are captured only on the accepted strobe.
- R9: An amplitude code of 0 disables correction, and the result is the nominal pair.
- R10: After reset both widths are 0, both flags are 0 and `ovr_vld` is 0.
- R11: When both limit conditions hold at once, the positive trigger takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| integ_vld | input | 1 | Integral valid strobe, once per period |
| integ | input | IW | Signed volt-second error integral |
| n0 | input | CW | Nominal half-wave width in clocks |
| amp | input | AW | Reference amplitude code V |
| lim_mult_pos | input | MW | Positive limit in units of V |
| lim_mult_neg | input | MW | Negative limit magnitude in units of V |
| np_out | output | CW | Positive half-wave width for the next period |
| nn_out | output | CW | Negative half-wave width for the next period |
| ovr_vld | output | 1 | One-cycle strobe marking a corrected result |
| trig_pos | output | 1 | Last result came from a positive trigger |
| trig_neg | output | 1 | Last result came from a negative trigger |

## Verification
Several internal faults show up at the ports as wrong width values:
- A wrong quotient bit in the divider changes the skew.
- A flipped direction register swaps the short and long half-waves.
- A dropped clamp lets a width exceed the maximum-duty count.

These errors appear on the very cycle the result is written. A fault in the sequencing moves the result edge or produces a second override strobe. An evaluation that restarts while busy also appears this way: the widths then belong to the wrong integral. The reference model predicts every output on every clock, so such faults are caught within one evaluation window of about 33 cycles.

// File: rtl/vsec_pkg.sv
package vsec_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vsec_state_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_POS  = 2'd1,
    DIR_NEG  = 2'd2
  } vsec_dir_e;

endpackage

// File: rtl/vsec_limit_cmp.sv
module vsec_limit_cmp
  import vsec_pkg::*;
#(
  parameter int IW = 32,
  parameter int AW = 12,
  parameter int MW = 10
) (
  input  logic signed [IW-1:0] integ,
  input  logic        [AW-1:0] amp,
  input  logic        [MW-1:0] mult_pos,
  input  logic        [MW-1:0] mult_neg,
  output vsec_dir_e            dir,
  output logic        [IW-1:0] mag
);

  localparam int PW = AW + MW;
  localparam int XW = ((IW > PW) ? IW : PW) + 2;

  logic        [PW-1:0] lim_p;
  logic        [PW-1:0] lim_n;
  logic signed [XW-1:0] e_x;
  logic signed [XW-1:0] lp_x;
  logic signed [XW-1:0] ln_x;

  always_comb begin
    lim_p = PW'(amp) * PW'(mult_pos);
    lim_n = PW'(amp) * PW'(mult_neg);
    e_x   = {{(XW-IW){integ[IW-1]}}, integ};
    lp_x  = {{(XW-PW){1'b0}}, lim_p};
    ln_x  = -$signed({{(XW-PW){1'b0}}, lim_n});
    dir   = DIR_NONE;
    if (amp != '0) begin
      if (e_x >= lp_x) begin
        dir = DIR_POS;
      end else if (e_x <= ln_x) begin
        dir = DIR_NEG;
      end
    end
    mag = integ[IW-1] ? $unsigned(-integ) : $unsigned(integ);
  end

endmodule

// File: rtl/vsec_seq_div.sv
module vsec_seq_div #(
  parameter int NW = 32,
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quot
);

  localparam int CNW = $clog2(NW + 1);

  logic [NW-1:0]  quo_q, quo_d;
  logic [DW-1:0]  rem_q, rem_d;
  logic [DW-1:0]  dvs_q, dvs_d;
  logic [CNW-1:0] cnt_q, cnt_d;
  logic           run_q, run_d;
  logic           done_q, done_d;
  logic [DW:0]    rem_sh;
  logic [DW:0]    diff;
  logic           fits;

  always_comb begin
    rem_sh = {rem_q, quo_q[NW-1]};
    diff   = rem_sh - {1'b0, dvs_q};
    fits   = (rem_sh >= {1'b0, dvs_q});
  end

  always_comb begin
    quo_d  = quo_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (start) begin
      quo_d = dividend;
      rem_d = '0;
      dvs_d = divisor;
      cnt_d = CNW'(NW);
      run_d = 1'b1;
    end else if (run_q) begin
      quo_d = {quo_q[NW-2:0], fits};
      rem_d = fits ? diff[DW-1:0] : rem_sh[DW-1:0];
      cnt_d = cnt_q - CNW'(1);
      if (cnt_q == CNW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quot = quo_q;

  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && dvs_q != '0) |-> (rem_q < dvs_q)); // R3

  AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q); // R8

endmodule

// File: rtl/vsec_skew_apply.sv
module vsec_skew_apply
  import vsec_pkg::*;
#(
  parameter int          IW      = 32,
  parameter int          CW      = 12,
  parameter int unsigned MAX_CNT = 1100
) (
  input  logic [CW-1:0] n0,
  input  logic [IW-1:0] skew,
  input  vsec_dir_e     dir,
  output logic [CW-1:0] np,
  output logic [CW-1:0] nn
);

  localparam int SW = ((IW > CW) ? IW : CW) + 1;
  localparam logic [SW-1:0] MAX_X = SW'(MAX_CNT);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_CNT);

  logic [SW-1:0] n0_x, sk_x, sum, dif;
  logic [CW-1:0] long_w, short_w, nom_w;

  always_comb begin
    n0_x    = SW'(n0);
    sk_x    = SW'(skew);
    sum     = n0_x + sk_x;
    dif     = n0_x - sk_x;
    long_w  = (sum > MAX_X) ? MAX_C : sum[CW-1:0];
    if (sk_x >= n0_x) begin
      short_w = '0;
    end else if (dif > MAX_X) begin
      short_w = MAX_C;
    end else begin
      short_w = dif[CW-1:0];
    end
    nom_w   = (n0_x > MAX_X) ? MAX_C : n0;
    unique case (dir)
      DIR_POS: begin
        np = short_w;
        nn = long_w;
      end
      DIR_NEG: begin
        np = long_w;
        nn = short_w;
      end
      default: begin
        np = nom_w;
        nn = nom_w;
      end
    endcase
  end

endmodule

// File: rtl/vsec_skew_corrector.sv
module vsec_skew_corrector
  import vsec_pkg::*;
#(
  parameter int          IW      = 32,
  parameter int          CW      = 12,
  parameter int          AW      = 12,
  parameter int          MW      = 10,
  parameter int unsigned MAX_CNT = 1100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 integ_vld,
  input  logic signed [IW-1:0] integ,
  input  logic        [CW-1:0] n0,
  input  logic        [AW-1:0] amp,
  input  logic        [MW-1:0] lim_mult_pos,
  input  logic        [MW-1:0] lim_mult_neg,
  output logic        [CW-1:0] np_out,
  output logic        [CW-1:0] nn_out,
  output logic                 ovr_vld,
  output logic                 trig_pos,
  output logic                 trig_neg
);

  localparam int DW = AW + 1;
  localparam logic [CW-1:0] MAX_C = CW'(MAX_CNT);

  vsec_state_e   st_q, st_d;
  vsec_dir_e     dir_cmp, dir_q, dir_d;
  logic [CW-1:0] n0_q, n0_d;
  logic [CW-1:0] np_q, np_d, nn_q, nn_d;
  logic          tp_q, tp_d, tn_q, tn_d, ovr_q, ovr_d;
  logic [IW-1:0] mag;
  logic [IW-1:0] quot;
  logic [CW-1:0] np_w, nn_w;
  logic          div_done;
  logic          cap_en, upd_en;

  vsec_limit_cmp #(.IW(IW), .AW(AW), .MW(MW)) u_cmp (
    .integ    (integ),
    .amp      (amp),
    .mult_pos (lim_mult_pos),
    .mult_neg (lim_mult_neg),
    .dir      (dir_cmp),
    .mag      (mag)
  );

  vsec_seq_div #(.NW(IW), .DW(DW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cap_en),
    .dividend (mag),
    .divisor  ({amp, 1'b0}),
    .done     (div_done),
    .quot     (quot)
  );

  vsec_skew_apply #(.IW(IW), .CW(CW), .MAX_CNT(MAX_CNT)) u_apply (
    .n0   (n0_q),
    .skew (quot),
    .dir  (dir_q),
    .np   (np_w),
    .nn   (nn_w)
  );

  always_comb begin
    cap_en = (st_q == ST_IDLE) && integ_vld;
    upd_en = (st_q == ST_RUN) && div_done;
    st_d   = st_q;
    if (cap_en) begin
      st_d = ST_RUN;
    end else if (upd_en) begin
      st_d = ST_IDLE;
    end
    dir_d = cap_en ? dir_cmp : dir_q;
    n0_d  = cap_en ? n0 : n0_q;
    np_d  = upd_en ? np_w : np_q;
    nn_d  = upd_en ? nn_w : nn_q;
    tp_d  = upd_en ? (dir_q == DIR_POS) : tp_q;
    tn_d  = upd_en ? (dir_q == DIR_NEG) : tn_q;
    ovr_d = upd_en && (dir_q != DIR_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dir_q <= DIR_NONE;
      n0_q  <= '0;
      np_q  <= '0;
      nn_q  <= '0;
      tp_q  <= 1'b0;
      tn_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      dir_q <= dir_d;
      n0_q  <= n0_d;
      np_q  <= np_d;
      nn_q  <= nn_d;
      tp_q  <= tp_d;
      tn_q  <= tn_d;
      ovr_q <= ovr_d;
    end
  end

  assign np_out   = np_q;
  assign nn_out   = nn_q;
  assign ovr_vld  = ovr_q;
  assign trig_pos = tp_q;
  assign trig_neg = tn_q;

  AST_OVR_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_vld |-> $onehot({trig_pos, trig_neg})); // R11

  AST_POS_SHORTENS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_vld && trig_pos) |-> (np_out <= nn_out)); // R1

  AST_NEG_LENGTHENS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_vld && trig_neg) |-> (np_out >= nn_out)); // R2

  AST_QUIET_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_pos && !trig_neg) |-> (np_out == nn_out)); // R4

  AST_WIDTH_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (np_out <= MAX_C) && (nn_out <= MAX_C)); // R5

  AST_OVR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_vld |=> !ovr_vld); // R6

  AST_BUSY_HOLDS_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> $stable(n0_q)); // R8

endmodule

// File: tb/sim_vsec_skew_corrector.sv
`timescale 1ns/1ps
module sim_vsec_skew_corrector;
  localparam int IW  = 32;
  localparam int CW  = 12;
  localparam int AW  = 12;
  localparam int MW  = 10;
  localparam int MAX = 1100;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 integ_vld = 1'b0;
  logic signed [IW-1:0] integ = '0;
  logic        [CW-1:0] n0 = '0;
  logic        [AW-1:0] amp = '0;
  logic        [MW-1:0] mp = 10'd400;
  logic        [MW-1:0] mn = 10'd400;
  logic        [CW-1:0] np_out, nn_out;
  logic                 ovr_vld, trig_pos, trig_neg;

  int    n_chk = 0;
  int    n_bad = 0;
  int    ovr_cnt = 0;
  bit    cmp_on = 0;
  bit    fin = 0;
  string tag = "R10";

  always #2.5 clk = ~clk;

  vsec_skew_corrector #(.IW(IW), .CW(CW), .AW(AW), .MW(MW), .MAX_CNT(MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .integ_vld(integ_vld), .integ(integ), .n0(n0),
    .amp(amp), .lim_mult_pos(mp), .lim_mult_neg(mn), .np_out(np_out),
    .nn_out(nn_out), .ovr_vld(ovr_vld), .trig_pos(trig_pos), .trig_neg(trig_neg)
  );

  // behavioural reference model
  int m_np, m_nn, p_np, p_nn, m_cnt;
  bit m_tp, m_tn, m_ovr, m_busy, p_tp, p_tn;

  task automatic predict();
    longint e, lp, ln, sk, lo, sh, nom, nv;
    e   = longint'(integ);
    nv  = longint'(n0);
    lp  = longint'(mp) * longint'(amp);
    ln  = longint'(mn) * longint'(amp);
    nom = (nv > MAX) ? MAX : nv;
    p_tp = 0; p_tn = 0;
    if (amp != 0) begin
      if (e >= lp) p_tp = 1;
      else if (e <= -ln) p_tn = 1;
    end
    sk = (amp != 0) ? ((e < 0 ? -e : e) / (2 * longint'(amp))) : 0;
    lo = nv + sk; if (lo > MAX) lo = MAX;
    sh = (sk >= nv) ? 0 : nv - sk; if (sh > MAX) sh = MAX;
    if (p_tp) begin p_np = int'(sh); p_nn = int'(lo); end
    else if (p_tn) begin p_np = int'(lo); p_nn = int'(sh); end
    else begin p_np = int'(nom); p_nn = int'(nom); end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_np = 0; m_nn = 0; m_tp = 0; m_tn = 0; m_ovr = 0; m_busy = 0; m_cnt = 0;
    end else begin
      m_ovr = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_np = p_np; m_nn = p_nn; m_tp = p_tp; m_tn = p_tn;
          m_ovr = p_tp | p_tn; m_busy = 0;
        end
      end else if (integ_vld) begin
        predict();
        m_busy = 1; m_cnt = IW + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (ovr_vld === 1'b1) ovr_cnt++;
    if (cmp_on) begin
      n_chk++;
      if (np_out !== CW'(m_np) || nn_out !== CW'(m_nn) || trig_pos !== m_tp ||
          trig_neg !== m_tn || ovr_vld !== m_ovr) begin
        n_bad++;
        $display("FAIL %s cycle model: actual np=%0d nn=%0d tp=%0b tn=%0b ovr=%0b expected np=%0d nn=%0d tp=%0b tn=%0b ovr=%0b",
                 tag, np_out, nn_out, trig_pos, trig_neg, ovr_vld, m_np, m_nn, m_tp, m_tn, m_ovr);
      end
    end
  end

  task automatic chk(string t, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  task automatic chk_out(string t, int enp, int enn, int etp, int etn, int eovr);
    chk(t, "np_out", np_out, enp);
    chk(t, "nn_out", nn_out, enn);
    chk(t, "trig_pos", trig_pos, etp);
    chk(t, "trig_neg", trig_neg, etn);
    chk(t, "ovr_vld", ovr_vld, eovr);
  endtask

  task automatic run_eval(longint e, int n, int a);
    @(negedge clk);
    integ = IW'(e); n0 = CW'(n); amp = AW'(a); integ_vld = 1'b1;
    @(negedge clk);
    integ_vld = 1'b0;
    repeat (IW + 1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1;
    tag = "R10"; chk_out("R10", 0, 0, 0, 0, 0);

    tag = "R2"; run_eval(-40000, 300, 100);
    chk_out("R2", 500, 100, 0, 1, 1);
    @(negedge clk);
    chk("R6", "ovr_vld after one cycle", ovr_vld, 0);

    tag = "R1"; run_eval(45000, 300, 100);
    chk_out("R1", 75, 525, 1, 0, 1);

    tag = "R6"; run_eval(39999, 300, 100);
    chk_out("R6", 300, 300, 0, 0, 0);

    tag = "R1"; run_eval(40000, 300, 100);
    chk_out("R1", 100, 500, 1, 0, 1);

    tag = "R4"; run_eval(-39999, 300, 100);
    chk_out("R4", 300, 300, 0, 0, 0);

    tag = "R3"; run_eval(-40001, 300, 100);
    chk_out("R3", 500, 100, 0, 1, 1);
    mp = 10'd1; mn = 10'd1;
    run_eval(-301, 300, 50);
    chk_out("R3", 303, 297, 0, 1, 1);
    mp = 10'd400; mn = 10'd400;

    tag = "R5"; run_eval(-100000, 1000, 100);
    chk_out("R5", 1100, 500, 0, 1, 1);
    run_eval(100000, 100, 100);
    chk_out("R5", 0, 600, 1, 0, 1);
    run_eval(0, 2000, 100);
    chk_out("R5", 1100, 1100, 0, 0, 0);

    tag = "R9"; run_eval(1000000, 300, 0);
    chk_out("R9", 300, 300, 0, 0, 0);

    tag = "R11"; mp = '0; mn = '0;
    run_eval(0, 300, 100);
    chk_out("R11", 300, 300, 1, 0, 1);
    mp = 10'd400; mn = 10'd400;

    tag = "R7";
    @(negedge clk);
    integ = -32'sd50000; n0 = 12'd400; amp = 12'd100; integ_vld = 1'b1;
    @(negedge clk);
    integ_vld = 1'b0;
    repeat (IW) @(negedge clk);
    chk("R7", "np_out one edge early", np_out, 300);
    chk("R7", "ovr_vld one edge early", ovr_vld, 0);
    @(negedge clk);
    chk("R7", "np_out on result edge", np_out, 650);
    chk("R7", "ovr_vld on result edge", ovr_vld, 1);

    tag = "R8";
    repeat (3) @(negedge clk);
    base = ovr_cnt;
    integ = -32'sd40000; n0 = 12'd300; amp = 12'd100; integ_vld = 1'b1;
    @(negedge clk);
    integ_vld = 1'b0;
    repeat (4) @(negedge clk);
    integ = 32'sd90000; n0 = 12'd700; integ_vld = 1'b1;
    @(negedge clk);
    integ_vld = 1'b0;
    repeat (IW + 2 - 6) @(negedge clk);
    chk_out("R8", 500, 100, 0, 1, 1);
    repeat (50) @(negedge clk);
    chk("R8", "override pulses", ovr_cnt - base, 1);
    chk("R8", "np_out held", np_out, 500);

    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule